// File: doc/BRIEF.md
# Muxed Interrupt Source Vector Unit

This unit sits between seven interrupt-producing functions and a downstream interrupt presenter. Each producer reports its level through an event port (an index plus the new level). The unit latches the level into a status bit, keeps six vector registers that hold a target server, a priority and a source number, and drives one of eight output lines for each vector. The source number stored in a vector selects which line that vector drives. Inputs 0 and 1 are merged onto vector 0. Their shared line stays high until both of them have been cleared.

A priority of all ones masks a vector. Each vector carries a pending flag that follows the rule "level asserted and not masked". The flag is re-evaluated whenever an event reaches that vector, and it is cleared at once when a masking priority is written. Software reaches the vectors and the two status words through one 3-bit address with a write strobe and a combinational read port. The downstream presenter receives each vector's server without its two link-pointer bits, together with the vector's priority.

Top module: `irq_vec_unit`

## Requirements
- R1: After reset, vector i (address i, 0 to 5) reads priority 0xFF in bits [39:32], source number i in bits [31:29], server 0 and pending 0. Both status words read zero and all output lines are low.
- R2: An event with index 0 to 6 stores its level in a status bit after the next clock edge. Index 0 maps to bit 47 and index 1 to bit 46 of address 6. Index k (2 to 6) maps to bit 38-k of address 7. All other status bits read zero.
- R3: Output line s is high exactly when at least one vector whose source field equals s has its level asserted. The level of vector 0 is status 0 OR status 1, and the level of vector v (1 to 5) is status v+1. Masking does not affect the lines.
- R4: The line driven by vector 0 stays high while either input 0 or input 1 is set. It falls only after both have been cleared.
- R5: When an event reaches a vector, pending (bit 24) becomes the vector's new level AND (priority != 0xFF). Events for other vectors leave the flag unchanged.
- R6: An accepted write whose priority is 0xFF clears pending at once. An accepted write with any other priority leaves pending unchanged. If an event and a write reach the same vector in the same cycle, pending is evaluated with the written priority.
- R7: A write to address 0 to 5 updates only server [55:40], priority [39:32] and source [31:29]. Every other bit of the write data is ignored.
- R8: A vector write whose source field is 6 or 7 is rejected, and the register keeps all its old contents.
- R9: For each vector v, srv_o[14v+13:14v] carries server bits [15:2] and prio_o[8v+7:8v] carries the priority.
- R10: An event with index 7 changes no status bit and no pending flag. It raises err_o for exactly the cycle that follows it.
- R11: Writes to addresses 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Level-change event strobe |
| evt_idx_i | input | 3 | Input index of the event |
| evt_level_i | input | 1 | New level for the indexed input |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for read and write |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Combinational read data at addr_i |
| line_o | output | 8 | Interrupt output lines, indexed by source number |
| err_o | output | 1 | Out-of-range event index flag |
| srv_o | output | 84 | Per-vector server with link bits removed |
| prio_o | output | 48 | Per-vector priority |

## Verification
Every event and write is sampled on one rising edge, and its effect appears on that same edge. Status, pending, the register fields, srv_o, prio_o and line_o are therefore all correct by the following falling edge, and err_o is high for exactly that one cycle. The bench holds a behavioural model that it updates at each rising edge from the inputs it drove. At every falling edge it compares all outputs and sweeps the eight read addresses, finishing the sweep before the next rising edge. The directed checks read back at that same falling edge, so every expected result is one clock after its stimulus.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int unsigned NUM_IN   = 7;
  localparam int unsigned NUM_VEC  = 6;
  localparam int unsigned DATA_W   = 64;
  localparam int unsigned SRV_W    = 16;
  localparam int unsigned PRIO_W   = 8;
  localparam int unsigned SRC_W    = 3;
  localparam int unsigned LINK_W   = 2;
  localparam int unsigned IDX_W    = 3;
  localparam int unsigned ADDR_W   = 3;
  // register field layout
  localparam int unsigned SRV_LSB  = 40;
  localparam int unsigned PRIO_LSB = 32;
  localparam int unsigned SRC_LSB  = 29;
  localparam int unsigned PEND_BIT = 24;
  // status layout
  localparam int unsigned SHARED_A_BIT = 47;
  localparam int unsigned SHARED_B_BIT = 46;
  localparam int unsigned STAT_HI_BIT  = 36;
  localparam int unsigned ADDR_SHARED  = 6;
  localparam int unsigned ADDR_STAT    = 7;

  typedef struct packed {
    logic [SRV_W-1:0]  srv;
    logic [PRIO_W-1:0] prio;
    logic [SRC_W-1:0]  src;
  } vec_cfg_t;
endpackage

// File: rtl/irqv_status.sv
module irqv_status
  import irqv_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               evt_valid_i,
  input  logic [IDX_W-1:0]   evt_idx_i,
  input  logic               evt_level_i,
  output logic [NUM_IN-1:0]  stat_o,
  output logic [NUM_VEC-1:0] lvl_o,
  output logic [NUM_VEC-1:0] lvl_nxt_o,
  output logic [NUM_VEC-1:0] hit_o,
  output logic               err_o
);
  logic [NUM_IN-1:0] stat_q, stat_d;
  logic              idx_ok;
  logic              err_q;

  assign idx_ok = evt_idx_i < IDX_W'(NUM_IN);

  always_comb begin
    stat_d = stat_q;
    if (evt_valid_i && idx_ok) stat_d[evt_idx_i] = evt_level_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      err_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      err_q  <= evt_valid_i && !idx_ok;
    end
  end

  // inputs 0 and 1 merge onto vector 0
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    if (v == 0) begin : g_shared
      assign lvl_o[v]     = stat_q[0] | stat_q[1];
      assign lvl_nxt_o[v] = stat_d[0] | stat_d[1];
      assign hit_o[v]     = evt_valid_i && (evt_idx_i <= IDX_W'(1));
    end else begin : g_single
      assign lvl_o[v]     = stat_q[v+1];
      assign lvl_nxt_o[v] = stat_d[v+1];
      assign hit_o[v]     = evt_valid_i && (evt_idx_i == IDX_W'(v + 1));
    end
  end

  assign stat_o = stat_q;
  assign err_o  = err_q;

  AST_BAD_IDX_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && !idx_ok) |=> $stable(stat_q));  // R10
  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && !idx_ok) |=> err_o);  // R10
  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && idx_ok) |=> !err_o);  // R10
endmodule

// File: rtl/irqv_vector.sv
module irqv_vector
  import irqv_pkg::*;
#(
  parameter int unsigned IDX = 0
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_en_i,
  input  vec_cfg_t wr_cfg_i,
  input  logic     hit_i,
  input  logic     lvl_nxt_i,
  output vec_cfg_t cfg_o,
  output logic     pend_o
);
  vec_cfg_t cfg_q, cfg_d;
  logic     pend_q, pend_d;
  logic     wr_ok, masked_d;

  assign wr_ok    = wr_en_i && (wr_cfg_i.src < SRC_W'(NUM_VEC));
  assign cfg_d    = wr_ok ? wr_cfg_i : cfg_q;
  assign masked_d = &cfg_d.prio;

  always_comb begin
    if (hit_i)         pend_d = lvl_nxt_i & ~masked_d;
    else if (masked_d) pend_d = 1'b0;
    else               pend_d = pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.srv  <= '0;
      cfg_q.prio <= '1;
      cfg_q.src  <= SRC_W'(IDX);
      pend_q     <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      pend_q <= pend_d;
    end
  end

  assign cfg_o  = cfg_q;
  assign pend_o = pend_q;

  AST_MASK_NO_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cfg_q.prio) |-> !pend_q);  // R5
  AST_SRC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.src < SRC_W'(NUM_VEC));  // R8
  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_i && !wr_en_i) |=> $stable(pend_q));  // R6
  AST_REJECT_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_cfg_i.src >= SRC_W'(NUM_VEC)) |=> $stable(cfg_q));  // R8
endmodule

// File: rtl/irqv_router.sv
module irqv_router
  import irqv_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8
) (
  input  logic [NUM_VEC-1:0][SRC_W-1:0] src_i,
  input  logic [NUM_VEC-1:0]            lvl_i,
  output logic [NUM_LINES-1:0]          line_o
);
  always_comb begin
    line_o = '0;
    for (int v = 0; v < NUM_VEC; v++) begin
      if (lvl_i[v]) line_o[src_i[v]] = 1'b1;
    end
  end
endmodule

// File: rtl/irq_vec_unit.sv
module irq_vec_unit
  import irqv_pkg::*;
#(
  parameter int unsigned NUM_LINES = 1 << SRC_W,
  localparam int unsigned SRV_OUT_W = SRV_W - LINK_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         evt_valid_i,
  input  logic [IDX_W-1:0]             evt_idx_i,
  input  logic                         evt_level_i,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [DATA_W-1:0]            rdata_o,
  output logic [NUM_LINES-1:0]         line_o,
  output logic                         err_o,
  output logic [NUM_VEC*SRV_OUT_W-1:0] srv_o,
  output logic [NUM_VEC*PRIO_W-1:0]    prio_o
);
  logic [NUM_IN-1:0]             stat;
  logic [NUM_VEC-1:0]            lvl, lvl_nxt, hit, pend;
  logic [NUM_VEC-1:0][SRC_W-1:0] src_vec;
  vec_cfg_t                      cfg [NUM_VEC];
  vec_cfg_t                      wr_cfg;
  logic                          unused_wdata;

  assign wr_cfg.srv   = wdata_i[SRV_LSB +: SRV_W];
  assign wr_cfg.prio  = wdata_i[PRIO_LSB +: PRIO_W];
  assign wr_cfg.src   = wdata_i[SRC_LSB +: SRC_W];
  assign unused_wdata = ^{wdata_i[DATA_W-1:SRV_LSB+SRV_W], wdata_i[SRC_LSB-1:0]};

  irqv_status u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_valid_i (evt_valid_i),
    .evt_idx_i   (evt_idx_i),
    .evt_level_i (evt_level_i),
    .stat_o      (stat),
    .lvl_o       (lvl),
    .lvl_nxt_o   (lvl_nxt),
    .hit_o       (hit),
    .err_o       (err_o)
  );

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    irqv_vector #(.IDX(v)) u_vec (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i && (addr_i == ADDR_W'(v))),
      .wr_cfg_i  (wr_cfg),
      .hit_i     (hit[v]),
      .lvl_nxt_i (lvl_nxt[v]),
      .cfg_o     (cfg[v]),
      .pend_o    (pend[v])
    );
    assign src_vec[v]                      = cfg[v].src;
    assign srv_o[v*SRV_OUT_W +: SRV_OUT_W] = cfg[v].srv[SRV_W-1:LINK_W];
    assign prio_o[v*PRIO_W +: PRIO_W]      = cfg[v].prio;
  end

  irqv_router #(.NUM_LINES(NUM_LINES)) u_router (
    .src_i  (src_vec),
    .lvl_i  (lvl),
    .line_o (line_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i < ADDR_W'(NUM_VEC)) begin
      for (int v = 0; v < NUM_VEC; v++) begin
        if (addr_i == ADDR_W'(v)) begin
          rdata_o[SRV_LSB +: SRV_W]   = cfg[v].srv;
          rdata_o[PRIO_LSB +: PRIO_W] = cfg[v].prio;
          rdata_o[SRC_LSB +: SRC_W]   = cfg[v].src;
          rdata_o[PEND_BIT]           = pend[v];
        end
      end
    end else if (addr_i == ADDR_W'(ADDR_SHARED)) begin
      rdata_o[SHARED_A_BIT] = stat[0];
      rdata_o[SHARED_B_BIT] = stat[1];
    end else begin
      for (int k = 2; k < NUM_IN; k++) rdata_o[STAT_HI_BIT + 2 - k] = stat[k];
    end
  end

  AST_SHARED_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat[0] | stat[1]) |-> line_o[cfg[0].src]);  // R4
  AST_LINE_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl == '0) |-> (line_o == '0));  // R3
endmodule

// File: tb/irq_vec_unit_tb.sv
module irq_vec_unit_tb;
  localparam time CLK_PERIOD = 20ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        evt_valid_i = 1'b0;
  logic [2:0]  evt_idx_i = '0;
  logic        evt_level_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [63:0] wdata_i = '0;
  logic [63:0] rdata_o;
  logic [7:0]  line_o;
  logic        err_o;
  logic [83:0] srv_o;
  logic [47:0] prio_o;

  int n_chk = 0;
  int n_err = 0;

  logic [15:0] m_srv  [6];
  logic [7:0]  m_prio [6];
  logic [2:0]  m_src  [6];
  logic        m_pend [6];
  logic [6:0]  m_stat;
  logic        m_err;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_vec_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_valid_i(evt_valid_i), .evt_idx_i(evt_idx_i),
    .evt_level_i(evt_level_i), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .line_o(line_o), .err_o(err_o), .srv_o(srv_o), .prio_o(prio_o)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic m_lvl(input int v);
    return (v == 0) ? (m_stat[0] | m_stat[1]) : m_stat[v+1];
  endfunction

  function automatic logic [63:0] m_read(input int a);
    logic [63:0] r = '0;
    if (a < 6) begin
      r[55:40] = m_srv[a]; r[39:32] = m_prio[a]; r[31:29] = m_src[a]; r[24] = m_pend[a];
    end else if (a == 6) begin
      r[47] = m_stat[0]; r[46] = m_stat[1];
    end else begin
      for (int k = 2; k < 7; k++) r[38-k] = m_stat[k];
    end
    return r;
  endfunction

  function automatic logic [63:0] mk(input logic [15:0] s, input logic [7:0] p, input logic [2:0] c);
    return {8'hC3, s, p, c, 29'h1100_0001};  // junk outside the fields
  endfunction

  function automatic logic [63:0] vec_word(input logic [15:0] s, input logic [7:0] p,
                                           input logic [2:0] c, input logic pd);
    return {8'h00, s, p, c, 4'h0, pd, 24'h0};
  endfunction

  task automatic m_reset();
    for (int v = 0; v < 6; v++) begin
      m_srv[v] = '0; m_prio[v] = 8'hFF; m_src[v] = 3'(v); m_pend[v] = 1'b0;
    end
    m_stat = '0; m_err = 1'b0;
  endtask

  task automatic m_update(input logic v, input logic [2:0] idx, input logic l,
                          input logic we, input logic [2:0] a, input logic [63:0] wd);
    int vv;
    if (we && a < 6 && wd[31:29] < 6) begin
      m_srv[a] = wd[55:40]; m_prio[a] = wd[39:32]; m_src[a] = wd[31:29];
      if (wd[39:32] == 8'hFF) m_pend[a] = 1'b0;
    end
    m_err = v && (idx == 3'd7);
    if (v && idx < 7) begin
      m_stat[idx] = l;
      vv = (idx <= 1) ? 0 : int'(idx) - 1;
      m_pend[vv] = m_lvl(vv) && (m_prio[vv] != 8'hFF);
    end
  endtask

  task automatic compare_all();
    logic [7:0] exp_line = '0;
    for (int v = 0; v < 6; v++) if (m_lvl(v)) exp_line[m_src[v]] = 1'b1;
    chk("R3 line_o", 128'(line_o), 128'(exp_line));
    chk("R10 err_o", 128'(err_o), 128'(m_err));
    for (int v = 0; v < 6; v++) begin
      chk("R9 srv_o", 128'(srv_o[v*14 +: 14]), 128'(m_srv[v][15:2]));
      chk("R9 prio_o", 128'(prio_o[v*8 +: 8]), 128'(m_prio[v]));
    end
    for (int a = 0; a < 8; a++) begin
      addr_i = 3'(a);
      #1;
      chk(a < 6 ? "R7 vector read" : "R2 status read", 128'(rdata_o), 128'(m_read(a)));
    end
  endtask

  task automatic step(input logic v, input logic [2:0] idx, input logic l,
                      input logic we, input logic [2:0] a, input logic [63:0] wd);
    evt_valid_i = v; evt_idx_i = idx; evt_level_i = l;
    wr_en_i = we; addr_i = a; wdata_i = wd;
    @(posedge clk_i);
    m_update(v, idx, l, we, a, wd);
    @(negedge clk_i);
    evt_valid_i = 1'b0; wr_en_i = 1'b0;
    compare_all();
  endtask

  task automatic evt(input logic [2:0] idx, input logic l);
    step(1'b1, idx, l, 1'b0, 3'd0, 64'h0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] wd);
    step(1'b0, 3'd0, 1'b0, 1'b1, a, wd);
  endtask

  task automatic rd(input logic [2:0] a, input logic [63:0] exp, input string tag);
    addr_i = a;
    #1;
    chk(tag, 128'(rdata_o), 128'(exp));
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    step(1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 64'h0);
    // R1 reset values
    rd(3'd0, 64'h0000_00FF_0000_0000, "R1 vector0 reset");
    rd(3'd3, 64'h0000_00FF_6000_0000, "R1 vector3 reset");
    rd(3'd6, 64'h0, "R1 shared status reset");
    rd(3'd7, 64'h0, "R1 status reset");
    chk("R1 lines reset", 128'(line_o), 128'(8'h00));

    wr(3'd0, mk(16'h1234, 8'h05, 3'd2));
    rd(3'd0, vec_word(16'h1234, 8'h05, 3'd2, 1'b0), "R7 fields only");

    evt(3'd0, 1'b1);
    chk("R3 line for src 2", 128'(line_o[2]), 128'(1'b1));
    rd(3'd0, vec_word(16'h1234, 8'h05, 3'd2, 1'b1), "R5 pending set");
    rd(3'd6, 64'h0000_8000_0000_0000, "R2 index0 bit47");
    chk("R9 server shifted", 128'(srv_o[13:0]), 128'(14'h048D));

    evt(3'd1, 1'b1);
    evt(3'd0, 1'b0);
    chk("R4 shared line held", 128'(line_o[2]), 128'(1'b1));
    rd(3'd6, 64'h0000_4000_0000_0000, "R2 index1 bit46");
    evt(3'd1, 1'b0);
    chk("R4 shared line released", 128'(line_o[2]), 128'(1'b0));

    evt(3'd3, 1'b1);
    rd(3'd7, 64'h0000_0008_0000_0000, "R2 index3 bit35");
    rd(3'd2, vec_word(16'h0, 8'hFF, 3'd2, 1'b0), "R5 masked no pending");
    chk("R3 masked still drives", 128'(line_o[2]), 128'(1'b1));

    wr(3'd2, mk(16'h0000, 8'h07, 3'd5));
    rd(3'd2, vec_word(16'h0, 8'h07, 3'd5, 1'b0), "R6 unmask keeps pending");
    chk("R3 line follows source", 128'(line_o), 128'(8'h20));
    evt(3'd3, 1'b1);
    rd(3'd2, vec_word(16'h0, 8'h07, 3'd5, 1'b1), "R5 pending after event");
    wr(3'd2, mk(16'hFFFF, 8'hFF, 3'd5));
    rd(3'd2, vec_word(16'hFFFF, 8'hFF, 3'd5, 1'b0), "R6 mask clears pending");
    chk("R3 line unaffected by mask", 128'(line_o[5]), 128'(1'b1));

    wr(3'd1, mk(16'h0001, 8'h01, 3'd6));
    rd(3'd1, vec_word(16'h0, 8'hFF, 3'd1, 1'b0), "R8 source 6 rejected");
    wr(3'd1, mk(16'h0001, 8'h01, 3'd7));
    rd(3'd1, vec_word(16'h0, 8'hFF, 3'd1, 1'b0), "R8 source 7 rejected");

    wr(3'd6, '1);
    wr(3'd7, '1);
    rd(3'd6, 64'h0, "R11 shared status write ignored");
    rd(3'd7, 64'h0000_0008_0000_0000, "R11 status write ignored");

    evt(3'd7, 1'b1);
    chk("R10 err pulse", 128'(err_o), 128'(1'b1));
    rd(3'd7, 64'h0000_0008_0000_0000, "R10 status unchanged");
    step(1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 64'h0);
    chk("R10 err one cycle", 128'(err_o), 128'(1'b0));

    for (int i = 0; i < 400; i++) begin
      logic [63:0] wd;
      wd = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) wd[39:32] = 8'hFF;
      step(1'($urandom_range(0, 2) != 0), 3'($urandom_range(0, 7)), 1'($urandom),
           1'($urandom_range(0, 3) == 0), 3'($urandom_range(0, 7)), wd);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule